// File: doc/BRIEF.md
# Periodic Interval Timer with Programmable Interrupt Vector

A memory-mapped down-counting timer for a single processor. Software writes an interval in bus clocks to the reload register and then sets the enable bit in the control register. From that moment the counter counts one step per clock. Each time the interval elapses it emits a one-cycle interrupt pulse and reloads itself. It keeps firing at that period until software clears the enable bit.

The interrupt is not fixed to a line. The control register carries an 8-bit trap number and a 4-bit priority. Each pulse comes with an 8-bit vector for the companion interrupt controller. The vector is formed by keeping the low six bits of the number, forcing the top two bits to `01`, and OR-ing in the priority shifted left by two. Vectors therefore always fall in the range 64 to 127.

A read-only register returns the bus clock period in nanoseconds, so software can convert intervals into time. Reads return data one clock after the read strobe.

Top module: `interval_timer`

## Requirements
- R1: After reset, the control, reload and count registers read 0, `irq_pulse` is low and `irq_vec` is 0.
- R2: The control register (offset 0x00) stores only bit 26 (enable), bits 23:20 (priority) and bits 19:12 (trap number). All other bits are dropped on write and read back as 0.
- R3: The reload register (offset 0x10) stores and returns a full 32-bit value.
- R4: The period register (offset 0x18) always reads the parameter `BUS_PERIOD_NS`, and writes to it are ignored.
- R5: The count register (offset 0x14) decreases by one per clock while enabled and holds while disabled. Writes to it are ignored.
- R6: A control write that turns enable from 0 to 1 loads the reload value N. The first pulse is seen in the cycle after the Nth clock edge following that write, and pulses repeat every N clocks without further writes.
- R7: For N of 2 or more, each pulse lasts exactly one clock.
- R8: A control write with bit 26 clear stops counting and suppresses any pulse from that clock edge onward, including one that would have fired on that same edge.
- R9: During a pulse, `irq_vec` equals 0x40 | number[5:0] | (priority << 2), using the fields of the control register.
- R10: A reload value of 0 gives an interval of 2^32 clocks. After enabling, the count reads 2^32 minus the clocks elapsed, and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data valid the next cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Trap vector that goes with the request |

## Verification
The periodic function is swept over intervals 1 to 8. Each interval is paired with a different number and priority, including numbers whose top bits are set. The sweep checks the pulse position, the gap between pulses and the vector formula together. Interval 1 separates continuous firing from the single-cycle pulses of longer intervals. A disable issued on the exact edge where a pulse is due shows whether the suppression is immediate or one cycle late. A zero interval, and reads of the count spaced a known number of cycles apart, show whether counting is exact and whether writes to read-only registers leak through.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_W = 5;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 5'h00;
  localparam logic [OFF_W-1:0] OFF_RELOAD = 5'h10;
  localparam logic [OFF_W-1:0] OFF_COUNT  = 5'h14;
  localparam logic [OFF_W-1:0] OFF_PERIOD = 5'h18;

  localparam int EN_BIT   = 26;
  localparam int PRIO_W   = 4;
  localparam int PRIO_LSB = 20;
  localparam int NUM_W    = 8;
  localparam int NUM_LSB  = 12;
  localparam int VEC_W    = 8;

  typedef struct packed {
    logic              en;
    logic [PRIO_W-1:0] prio;
    logic [NUM_W-1:0]  num;
  } tmr_ctrl_t;

  // Controller mapping: top two bits forced to 01, priority ORed in at bit 2.
  function automatic logic [VEC_W-1:0] form_vector(input tmr_ctrl_t c);
    logic [VEC_W-1:0] v;
    v = {2'b01, c.num[VEC_W-3:0]};
    v = v | (VEC_W'(c.prio) << 2);
    return v;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 5,
  parameter int BUS_PERIOD_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_val,
  output tmr_ctrl_t         ctrl,
  output logic [DATA_W-1:0] reload,
  output logic              start,
  output logic              stop,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);
  localparam logic [DATA_W-1:0] PERIOD_V = DATA_W'(BUS_PERIOD_NS);

  logic wr_ctrl;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign start   = wr_ctrl && bus_wdata[EN_BIT] && !ctrl.en;
  assign stop    = wr_ctrl && !bus_wdata[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        ctrl.en   <= bus_wdata[EN_BIT];
        ctrl.prio <= bus_wdata[PRIO_LSB +: PRIO_W];
        ctrl.num  <= bus_wdata[NUM_LSB +: NUM_W];
      end
      if (bus_addr == A_RELOAD) reload <= bus_wdata;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CTRL: begin
        rd_mux[EN_BIT]                = ctrl.en;
        rd_mux[PRIO_LSB +: PRIO_W]    = ctrl.prio;
        rd_mux[NUM_LSB +: NUM_W]      = ctrl.num;
      end
      A_RELOAD: rd_mux = reload;
      A_COUNT:  rd_mux = cnt_val;
      A_PERIOD: rd_mux = PERIOD_V;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_PERIOD_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_PERIOD) |=> (bus_rdata == PERIOD_V)); // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic run;
  assign run  = en && !stop;
  assign fire = run && (cnt == ONE);

  // A zero reload wraps to all-ones on the next step: interval 2^CNT_W.
  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= reload;
    else if (run) begin
      if (cnt == ONE)   cnt <= reload;
      else              cnt <= cnt - ONE;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cnt)); // R5
  AST_RELOAD_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt == $past(reload))); // R6
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  tmr_ctrl_t        ctrl,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
    end else begin
      irq_pulse <= fire;
      if (fire) irq_vec <= form_vector(ctrl);
    end
  end

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq_vec[VEC_W-1:VEC_W-2] == 2'b01)); // R9
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 5,
  parameter int BUS_PERIOD_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic [7:0]        irq_vec
);
  tmr_ctrl_t         ctrl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] cnt;
  logic              start;
  logic              stop;
  logic              fire;

  tmr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUS_PERIOD_NS(BUS_PERIOD_NS)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt),
    .ctrl(ctrl), .reload(reload), .start(start), .stop(stop),
    .bus_rdata(bus_rdata)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_counter (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .en(ctrl.en),
    .reload(reload), .cnt(cnt), .fire(fire)
  );

  tmr_irq_out u_irq (
    .clk(clk), .rst(rst), .fire(fire), .ctrl(ctrl),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec)
  );

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> !irq_pulse); // R8
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int PER = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_pulse;
  logic [7:0]    irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  interval_timer #(.DATA_W(DW), .ADDR_W(AW), .BUS_PERIOD_NS(PER)) u_interval_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [DW-1:0] ctrl_word(input logic [3:0] p, input logic [7:0] n);
    return (32'd1 << 26) | (DW'(p) << 20) | (DW'(n) << 12);
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] v, a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h10, v); chk("R1 reload", v, 0);
    rd(5'h14, v); chk("R1 count", v, 0);
    chk("R1 irq", DW'(irq_pulse), 0);
    chk("R1 vec", DW'(irq_vec), 0);

    // R3 reload storage
    wr(5'h10, 32'hA5C3_9F01); rd(5'h10, v); chk("R3 reload", v, 32'hA5C3_9F01);
    wr(5'h10, 32'h0); rd(5'h10, v); chk("R3 reload zero", v, 0);

    // R4 period read-only
    rd(5'h18, v); chk("R4 period", v, PER);
    wr(5'h18, 32'h1234); rd(5'h18, v); chk("R4 period after write", v, PER);

    // R2 masked control, also R10 with reload 0
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R2 ctrl mask", v, 32'h04FF_F000);
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk("R2 ctrl clear", v, 0);

    // R10 zero interval: write ends one half-cycle after the enabling edge E
    wr(5'h10, 32'h0);
    wr(5'h00, ctrl_word(4'h0, 8'h40));
    repeat (5) @(negedge clk);
    rd(5'h14, v); chk("R10 count wrap", v, 32'hFFFF_FFFB);
    begin
      int seen = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (irq_pulse) seen++;
      end
      chk("R10 no pulse", seen, 0);
    end
    wr(5'h00, 32'h0);

    // R6 R7 R9 sweep of interval, number and priority
    for (int n = 1; n <= 8; n++) begin
      logic [3:0] p;
      logic [7:0] num;
      logic [7:0] ev;
      int bad_irq, bad_vec;
      p   = 4'((n * 5) % 16);
      num = 8'((n * 53 + 17) % 256);
      ev  = 8'h40 | {2'b00, num[5:0]} | {2'b00, p, 2'b00};
      bad_irq = 0; bad_vec = 0;
      wr(5'h10, DW'(n));
      wr(5'h00, ctrl_word(p, num));
      for (int k = 1; k <= 3 * n + 1; k++) begin
        @(negedge clk);
        if (irq_pulse !== ((k % n) == 0)) begin
          bad_irq++;
          $display("FAIL R6/R7 n=%0d k=%0d actual=%b expected=%b", n, k, irq_pulse, (k % n) == 0);
        end
        if (irq_pulse && irq_vec !== ev) bad_vec++;
      end
      checks++; if (bad_irq != 0) errors++;
      chk("R9 vector", DW'(bad_vec), 0);
      wr(5'h00, 32'h0);
    end

    // R9 priority sweep with fixed high-bit number
    for (int p = 0; p < 16; p++) begin
      logic [7:0] ev;
      ev = 8'h40 | 8'h3F | 8'(p << 2);
      wr(5'h10, 32'd2);
      wr(5'h00, ctrl_word(4'(p), 8'hFF));
      @(negedge clk); @(negedge clk);
      chk("R9 prio pulse", DW'(irq_pulse), 1);
      chk("R9 prio vec", DW'(irq_vec), DW'(ev));
      wr(5'h00, 32'h0);
    end

    // R8 disable on the edge where a pulse is due
    wr(5'h10, 32'd5);
    wr(5'h00, ctrl_word(4'h3, 8'h05));
    repeat (4) @(negedge clk);
    wr(5'h00, 32'h0);
    chk("R8 suppressed", DW'(irq_pulse), 0);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (irq_pulse) seen++;
      end
      chk("R8 no later pulse", seen, 0);
    end

    // R5 hold while disabled
    rd(5'h14, a);
    repeat (7) @(negedge clk);
    rd(5'h14, b);
    chk("R5 hold", b, a);
    chk("R5 held value", a, 1);

    // R5 decrement rate and ignored count write
    wr(5'h10, 32'd100000);
    wr(5'h00, ctrl_word(4'h1, 8'h01));
    repeat (3) @(negedge clk);
    rd(5'h14, a);
    repeat (9) @(negedge clk);
    rd(5'h14, b);
    chk("R5 decrement", b, a - 32'd10);
    rd(5'h14, a);
    wr(5'h14, 32'd7);
    rd(5'h14, b);
    chk("R5 count write ignored", b, a - 32'd2);
    wr(5'h00, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule